// File: doc/BRIEF.md
# Serial Volume Control Register Interface

This block is the digital front end of a multichannel volume controller. A host writes it over a slow serial link made of a serial clock, a data line, an active-low write enable that acts as chip select, and an active-low load strobe. The block oversamples these pins on its own system clock. It shifts in 8-bit bytes and keeps the control codes that drive one master attenuator and six channel gain stages.

Two kinds of byte arrive, and the MSB tells them apart. A byte with the MSB set picks a target: the master level, one of the six channels, or a mute control slot. A byte with the MSB clear carries the new setting for the target picked last. Bits are shifted only while write enable is low. A setting changes only on the rising edge of load. When write enable and load are wired to one pin (3-wire use), the rising edge of that pin ends the byte and applies it in one step. The outputs come up muted after reset and stay muted until the host sends an unmute command.

Top module: `volctl_serial_regs`

## Requirements
- R1: A data bit is taken on each falling edge of `sclk` while `wr_n` is low, and bits arrive MSB first. Clock edges while `wr_n` is high shift nothing and cannot complete a byte.
- R2: A byte with bit 7 = 1 is an address byte. It stores bits [2:0] as the target selector (000 master, 001..110 channels 1..6, 111 mute slot), ignores bits [6:3], and changes no level or mute output.
- R3: While the selector is 000, a data byte (bit 7 = 0) copies its bits [6:0] into `master_code` (7F = 0 dB, 00 = -127 dB).
- R4: While the selector is n in 1..6, a data byte copies bits [4:0] into channel n's code, which sits at `ch_code[5*(n-1) +: 5]` (00 = +31 dB, 1F = 0 dB, 10 = midpoint). It also sets `ch_mute[n-1]` to the inverse of bit 5, so bit 5 = 0 mutes that channel.
- R5: While the selector is 111, a data byte sets `master_mute` to the inverse of its bit 0 (0 mutes, 1 unmutes) and changes no level code.
- R6: Outputs change only after a rising edge of `ld_n`. A byte that has been fully shifted but not yet loaded leaves every output unchanged.
- R7: A load that follows fewer than 8 bits since `wr_n` fell is ignored. If more than 8 bits were shifted, the last 8 form the byte.
- R8: With `wr_n` and `ld_n` driven together, the shared rising edge applies the byte just shifted.
- R9: After reset, `master_mute` = 1, `master_code` = 00, every channel code = 1F, every `ch_mute` bit = 0, and the selector = 111.
- R10: Transfers work with the serial clock idling either high or low.
- R11: The selector persists across loads, so successive data bytes all write the same target until the next address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; a bit is taken on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| wr_n | input | 1 | Active-low write enable and chip select |
| ld_n | input | 1 | Active-low load strobe; its rising edge applies the byte |
| master_code | output | 7 | Master attenuation code |
| ch_code | output | 30 | Six 5-bit channel gain codes; channel 1 in the low bits |
| master_mute | output | 1 | Global mute, 1 = muted |
| ch_mute | output | 6 | Per-channel mute, 1 = muted |

## Verification
The bench sweeps every master code and every code of every channel. It changes the clock polarity and the wiring mode from byte to byte, so a design that samples on the wrong edge, or that loses the first bit when the clock idles high, writes shifted values. In 4-wire transfers it compares the outputs after write enable rises and before load. A design that updates on the end of write instead of on load fails there. It loads a 5-bit fragment, a 12-bit run and a load pulse after clocking with write enable high. A design that counts badly either applies garbage or drops the tail byte. Address bytes with junk in bits [6:3], and mute commands sent to the 111 slot, must leave every level code untouched.

// File: rtl/volctl_serial_regs.sv
module volctl_serial_regs #(
  parameter int NCH  = 6,
  parameter int MW   = 7,
  parameter int CW   = 5,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              wr_n,
  input  logic              ld_n,
  output logic [MW-1:0]     master_code,
  output logic [NCH*CW-1:0] ch_code,
  output logic              master_mute,
  output logic [NCH-1:0]    ch_mute
);
  localparam int BW   = 8;
  localparam int AW   = 3;
  localparam int CNTW = $clog2(BW + 1);
  localparam logic [AW-1:0] SEL_MASTER = '0;
  localparam logic [AW-1:0] SEL_MUTE   = '1;
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(BW);

  logic [SYNC-1:0] ck_sy, d_sy, wr_sy, ld_sy;
  logic            ck_q, wr_q, ld_q;
  logic            ck_s, d_s, wr_s, ld_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy <= '0;
      d_sy  <= '0;
      wr_sy <= '1;
      ld_sy <= '1;
      ck_q  <= 1'b0;
      wr_q  <= 1'b1;
      ld_q  <= 1'b1;
    end else begin
      ck_sy <= {ck_sy[SYNC-2:0], sclk};
      d_sy  <= {d_sy[SYNC-2:0], sdata};
      wr_sy <= {wr_sy[SYNC-2:0], wr_n};
      ld_sy <= {ld_sy[SYNC-2:0], ld_n};
      ck_q  <= ck_s;
      wr_q  <= wr_s;
      ld_q  <= ld_s;
    end
  end

  assign ck_s = ck_sy[SYNC-1];
  assign d_s  = d_sy[SYNC-1];
  assign wr_s = wr_sy[SYNC-1];
  assign ld_s = ld_sy[SYNC-1];

  logic ck_fall, wr_fall, ld_rise, bit_take;
  assign ck_fall  = ck_q & ~ck_s;
  assign wr_fall  = wr_q & ~wr_s;
  assign ld_rise  = ~ld_q & ld_s;
  assign bit_take = ck_fall & ~wr_s;

  logic [BW-1:0]   sh;
  logic [CNTW-1:0] cnt;
  logic            full;
  assign full = (cnt == FULL_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else begin
      if (bit_take) sh <= {sh[BW-2:0], d_s};
      if (wr_fall)
        cnt <= bit_take ? CNTW'(1) : '0;
      else if (ld_rise)
        cnt <= '0;
      else if (bit_take && !full)
        cnt <= cnt + CNTW'(1);
    end
  end

  logic          apply, is_addr, data_wr;
  logic [AW-1:0] sel;
  assign apply   = ld_rise & full;
  assign is_addr = sh[BW-1];
  assign data_wr = apply & ~is_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel         <= SEL_MUTE;
      master_code <= '0;
      master_mute <= 1'b1;
    end else begin
      if (apply && is_addr) sel <= sh[AW-1:0];
      if (data_wr && sel == SEL_MASTER) master_code <= sh[MW-1:0];
      if (data_wr && sel == SEL_MUTE) master_mute <= ~sh[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = data_wr && (sel == AW'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_code[i*CW +: CW] <= '1;
        ch_mute[i]          <= 1'b0;
      end else if (hit) begin
        ch_code[i*CW +: CW] <= sh[CW-1:0];
        ch_mute[i]          <= ~sh[CW];
      end
    end
  end
endmodule

module volctl_serial_regs_chk #(
  parameter int NCH = 6,
  parameter int MW  = 7,
  parameter int CW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_rise,
  input logic              full,
  input logic              sh_msb,
  input logic              wr_s,
  input logic [3:0]        cnt,
  input logic [2:0]        sel,
  input logic [MW-1:0]     master_code,
  input logic [NCH*CW-1:0] ch_code,
  input logic              master_mute,
  input logic [NCH-1:0]    ch_mute
);
  // R6
  stable_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(master_code) && $stable(ch_code) && $stable(master_mute) && $stable(ch_mute));
  // R7
  partial_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && !full |=> $stable(sel) && $stable(master_code) && $stable(ch_code) && $stable(master_mute) && $stable(ch_mute));
  // R2
  addr_no_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && full && sh_msb |=> $stable(master_code) && $stable(ch_code) && $stable(master_mute) && $stable(ch_mute));
  // R1
  no_shift_wr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s && !ld_rise |=> $stable(cnt));
  // R5
  unmute_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_mute) |-> $past(ld_rise && full && !sh_msb && sel == 3'd7));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> master_mute && sel == 3'd7 && master_code == '0 && ch_code == '1 && ch_mute == '0);
endmodule

bind volctl_serial_regs volctl_serial_regs_chk #(.NCH(NCH), .MW(MW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_rise(ld_rise), .full(full), .sh_msb(sh[7]),
  .wr_s(wr_s), .cnt(cnt), .sel(sel), .master_code(master_code), .ch_code(ch_code),
  .master_mute(master_mute), .ch_mute(ch_mute)
);

// File: tb/volctl_serial_regs_tb.sv
module volctl_serial_regs_tb;
  localparam int H = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, sclk = 1'b0, sdata = 1'b0, wr_n = 1'b1, ld_n = 1'b1;
  logic [6:0]  master_code;
  logic [29:0] ch_code;
  logic        master_mute;
  logic [5:0]  ch_mute;

  volctl_serial_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .wr_n(wr_n), .ld_n(ld_n),
    .master_code(master_code), .ch_code(ch_code), .master_mute(master_mute), .ch_mute(ch_mute)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [6:0] e_m = 7'h00;
  logic [4:0] e_c [6];
  logic       e_mm = 1'b1;
  logic [5:0] e_cm = 6'h00;
  logic [2:0] e_sel = 3'd7;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "master_code", int'(master_code), int'(e_m));
    cmp(tag, "master_mute", int'(master_mute), int'(e_mm));
    cmp(tag, "ch_mute", int'(ch_mute), int'(e_cm));
    for (int i = 0; i < 6; i++)
      cmp(tag, $sformatf("ch%0d code", i + 1), int'(ch_code[5*i +: 5]), int'(e_c[i]));
  endtask

  task automatic model(input logic [7:0] b);
    if (b[7]) e_sel = b[2:0];
    else if (e_sel == 3'd0) e_m = b[6:0];
    else if (e_sel == 3'd7) e_mm = ~b[0];
    else begin
      e_c[e_sel - 1]  = b[4:0];
      e_cm[e_sel - 1] = ~b[5];
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode bit 0: clock idles high; mode bit 1: write and load driven together
  task automatic xfer(input logic [15:0] pat, input int n, input int mode, input string tag);
    logic idle_hi;
    logic tw;
    idle_hi = mode[0];
    tw = mode[1];
    sclk = idle_hi;
    hold(H);
    wr_n = 1'b0;
    if (tw) ld_n = 1'b0;
    hold(H);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = pat[i];
      hold(H);
      sclk = ~idle_hi;
      hold(H);
      sclk = idle_hi;
      hold(H);
    end
    if (tw) begin
      wr_n = 1'b1;
      ld_n = 1'b1;
    end else begin
      wr_n = 1'b1;
      hold(H + 6);
      check_all({tag, " R6 before load"});
      ld_n = 1'b0;
      hold(H);
      ld_n = 1'b1;
    end
    hold(8);
    if (n >= 8) model(pat[7:0]);
    check_all(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) e_c[i] = 5'h1F;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    check_all("R9 reset");

    // R5 R8: unmute through the mute slot in 3-wire mode
    xfer(16'h0087, 8, 2, "R2 R8");
    xfer(16'h0001, 8, 3, "R5 R8 unmute");
    xfer(16'h0000, 8, 0, "R5 mute");
    xfer(16'h0001, 8, 1, "R5 unmute");

    // R2: bits [6:3] are don't care; R3 R10 R11: full master sweep across modes
    xfer(16'h00F8, 8, 1, "R2 addr master");
    for (int v = 0; v < 128; v++)
      xfer(16'(v), 8, v % 4, "R3 R10 R11 master");

    // R4: every code of every channel, mute bit toggling
    for (int c = 1; c <= 6; c++) begin
      xfer(16'(8'h80 | c), 8, c % 4, "R2 R4 addr ch");
      for (int g = 0; g < 32; g++)
        xfer(16'({2'b00, g[0], g[4:0]}), 8, (g + c) % 4, "R4 R10 ch");
    end

    // R7: fragments ignored, long runs keep the tail
    xfer(16'h0080, 8, 0, "R7 addr master");
    xfer(16'h0015, 5, 0, "R7 partial 5 bits");
    xfer(16'h0005, 3, 2, "R7 partial 3 bits 3-wire");
    xfer(16'h0A55, 12, 1, "R7 12 bits");

    // R1: clocking with write high completes nothing
    sdata = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; hold(H);
      sclk = 1'b0; hold(H);
    end
    ld_n = 1'b0; hold(H); ld_n = 1'b1; hold(8);
    check_all("R1 clocks with write high");
    xfer(16'h0033, 8, 0, "R1 R11 after idle clocks");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule